// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is the in-order retirement stage of an out-of-order core. Each issued instruction takes one slot of a circular buffer, in program order. Execution units finish in any order and post their results on a shared result bus. Each result carries the index of the slot it belongs to. The oldest slot retires once its result is present. A retiring register operation drives a register-file write. A retiring store drives a memory write. A retiring branch that was mispredicted empties the whole buffer and drives a redirect target.

Between completion and retirement, the buffer also acts as an operand source. Any slot index can be looked up to fetch its finished value. A result arriving on the bus in the same cycle is forwarded to the lookup directly.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `full` is 0, `alloc_tag` is 0, and `reg_wr_en`, `mem_wr_en` and `flush` are all 0.
- R2: The kind code is 0 for a register operation, 1 for a store and 2 for a branch; code 3 is not used. A ready register operation at the head drives `reg_wr_en`=1. In that cycle `reg_wr_idx` is the low REG_W bits of its destination and `reg_wr_data` is its value.
- R3: `alloc_tag` shows the slot the next accepted allocation takes. It advances by one, modulo DEPTH, for each accepted allocation.
- R4: Nothing retires while the head slot has no result. Younger slots that have finished wait behind it.
- R5: At most one slot retires per cycle, in allocation order. A ready store at the head drives `mem_wr_en`=1, with `mem_wr_addr` set to its destination and `mem_wr_data` set to its value.
- R6: A ready branch at the head whose completion carried `cdb_mispredict`=1 raises `flush` for one cycle. In that cycle `redirect_pc` equals the branch's value, and no register or memory write is made.
- R7: A ready branch at the head whose completion carried `cdb_mispredict`=0 retires without any write and without `flush`.
- R8: `full` is 1 while all DEPTH slots are occupied. An allocation offered while `full` is 1 is ignored. `full` drops in the cycle after a retirement.
- R9: In the cycle after `flush`, the buffer is empty: no retirement, `full`=0, and `alloc_tag`=0. An allocation offered in the flush cycle is ignored.
- R10: `lookup_ready` and `lookup_value` give the ready flag and value of slot `lookup_tag`. When `cdb_valid` is 1 and `cdb_tag` equals `lookup_tag`, they return 1 and `cdb_value` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one slot at the tail |
| alloc_kind | input | 2 | Kind code of the new slot |
| alloc_dest | input | DEST_W | Register number or memory address |
| alloc_tag | output | IDX_W | Index the next allocation takes |
| full | output | 1 | All slots occupied; stall issue |
| cdb_valid | input | 1 | Completion present on the result bus |
| cdb_tag | input | IDX_W | Slot index of the completion |
| cdb_value | input | DATA_W | Result value, or target for a branch |
| cdb_mispredict | input | 1 | Branch completion was mispredicted |
| lookup_tag | input | IDX_W | Slot index for operand lookup |
| lookup_ready | output | 1 | Looked-up slot holds its result |
| lookup_value | output | DATA_W | Looked-up value |
| reg_wr_en | output | 1 | Register-file write from retirement |
| reg_wr_idx | output | REG_W | Register number written |
| reg_wr_data | output | DATA_W | Register data written |
| mem_wr_en | output | 1 | Memory write from a retiring store |
| mem_wr_addr | output | DEST_W | Store address |
| mem_wr_data | output | DATA_W | Store data |
| flush | output | 1 | Mispredicted branch retiring; discard all |
| redirect_pc | output | DATA_W | Correct successor address |

## Verification
The retirement outputs are combinational from the head slot, so a result posted at one clock edge appears on `reg_wr_en`, `mem_wr_en` or `flush` in the low phase right after that edge. Each following low phase shows the next slot. Allocation, the drop of `full` and the empty state after a flush all show in the low phase after the capturing edge. Lookups and same-cycle forwarding are combinational and settle before the next edge. The bench drives inputs and samples outputs only on falling edges, with a short settle delay for same-cycle lookups. It sweeps every slot of an 8-slot buffer, covering completion in reverse order, wraparound and a mid-stream flush.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic [1:0] {
      KIND_REG    = 2'd0,
      KIND_STORE  = 2'd1,
      KIND_BRANCH = 2'd2,
      KIND_NONE   = 2'd3
   } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             clear,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [CNT_W-1:0] occ,
   output logic             full
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   initial begin
      assert (DEPTH >= 2) else $error("rob_ptrs: DEPTH must be at least 2");
   end

   logic [IDX_W-1:0] head_nx, tail_nx;

   generate
      if (POW2) begin : g_wrap_free
         assign head_nx = head + 1'b1;
         assign tail_nx = tail + 1'b1;
      end else begin : g_wrap_cmp
         assign head_nx = (head == LAST_IDX) ? '0 : head + 1'b1;
         assign tail_nx = (tail == LAST_IDX) ? '0 : tail + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
      end else begin
         if (push) tail <= tail_nx;
         if (pop)  head <= head_nx;
         case ({push, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   assign full = (occ == FULL_CNT);
endmodule

// File: rtl/rob_store.sv
module rob_store #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int DEST_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_alloc,
   input  logic [IDX_W-1:0]  alloc_idx,
   input  logic [1:0]        alloc_kind,
   input  logic [DEST_W-1:0] alloc_dest,
   input  logic              cdb_valid,
   input  logic [IDX_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_value,
   input  logic              cdb_mispredict,
   input  logic [IDX_W-1:0]  head_idx,
   output logic [1:0]        head_kind,
   output logic [DEST_W-1:0] head_dest,
   output logic [DATA_W-1:0] head_value,
   output logic              head_ready,
   output logic              head_mispred,
   input  logic [IDX_W-1:0]  lookup_tag,
   output logic              lookup_ready,
   output logic [DATA_W-1:0] lookup_value
);
   logic [1:0]        kind_q   [DEPTH];
   logic [DEST_W-1:0] dest_q   [DEPTH];
   logic [DATA_W-1:0] value_q  [DEPTH];
   logic              ready_q  [DEPTH];
   logic              mispr_q  [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_slot
         localparam logic [IDX_W-1:0] ME = IDX_W'(e);
         wire take = wr_alloc && (alloc_idx == ME);
         wire done = cdb_valid && (cdb_tag == ME);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               kind_q[e]  <= '0;
               dest_q[e]  <= '0;
               value_q[e] <= '0;
               ready_q[e] <= 1'b0;
               mispr_q[e] <= 1'b0;
            end else if (take) begin
               kind_q[e]  <= alloc_kind;
               dest_q[e]  <= alloc_dest;
               ready_q[e] <= 1'b0;
               mispr_q[e] <= 1'b0;
            end else if (done) begin
               value_q[e] <= cdb_value;
               ready_q[e] <= 1'b1;
               mispr_q[e] <= cdb_mispredict;
            end
         end
      end
   endgenerate

   assign head_kind    = kind_q[head_idx];
   assign head_dest    = dest_q[head_idx];
   assign head_value   = value_q[head_idx];
   assign head_ready   = ready_q[head_idx];
   assign head_mispred = mispr_q[head_idx];

   wire hit = cdb_valid && (cdb_tag == lookup_tag);
   assign lookup_ready = hit || ready_q[lookup_tag];
   assign lookup_value = hit ? cdb_value : value_q[lookup_tag];
endmodule

// File: rtl/rob_retire.sv
module rob_retire
   import rob_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEST_W = 16,
   parameter int REG_W  = 5
) (
   input  logic              nonempty,
   input  logic [1:0]        head_kind,
   input  logic [DEST_W-1:0] head_dest,
   input  logic [DATA_W-1:0] head_value,
   input  logic              head_ready,
   input  logic              head_mispred,
   output logic              retire,
   output logic              reg_wr_en,
   output logic [REG_W-1:0]  reg_wr_idx,
   output logic              mem_wr_en,
   output logic              flush
);
   rob_kind_e kind;
   assign kind = rob_kind_e'(head_kind);

   always_comb begin
      retire    = nonempty && head_ready;
      reg_wr_en = 1'b0;
      mem_wr_en = 1'b0;
      flush     = 1'b0;
      if (retire) begin
         unique case (kind)
            KIND_REG:    reg_wr_en = 1'b1;
            KIND_STORE:  mem_wr_en = 1'b1;
            KIND_BRANCH: flush     = head_mispred;
            default:     ;
         endcase
      end
   end

   assign reg_wr_idx = head_dest[REG_W-1:0];
endmodule

// File: rtl/spec_rob.sv
module spec_rob #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int DEST_W = 16,
   parameter int REG_W  = 5,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [1:0]        alloc_kind,
   input  logic [DEST_W-1:0] alloc_dest,
   output logic [IDX_W-1:0]  alloc_tag,
   output logic              full,
   input  logic              cdb_valid,
   input  logic [IDX_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_value,
   input  logic              cdb_mispredict,
   input  logic [IDX_W-1:0]  lookup_tag,
   output logic              lookup_ready,
   output logic [DATA_W-1:0] lookup_value,
   output logic              reg_wr_en,
   output logic [REG_W-1:0]  reg_wr_idx,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              mem_wr_en,
   output logic [DEST_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              flush,
   output logic [DATA_W-1:0] redirect_pc
);
   initial begin
      assert (REG_W <= DEST_W) else $error("spec_rob: REG_W exceeds DEST_W");
      assert (DATA_W >= 1)     else $error("spec_rob: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  head;
   logic [CNT_W-1:0]  occ;
   logic              retire, push, pop;
   logic [1:0]        head_kind;
   logic [DEST_W-1:0] head_dest;
   logic [DATA_W-1:0] head_value;
   logic              head_ready, head_mispred;

   assign push = alloc_valid && !full && !flush;
   assign pop  = retire && !flush;

   rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .clear(flush),
      .head(head), .tail(alloc_tag), .occ(occ), .full(full)
   );

   rob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_alloc(push), .alloc_idx(alloc_tag), .alloc_kind(alloc_kind),
      .alloc_dest(alloc_dest),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
      .cdb_mispredict(cdb_mispredict),
      .head_idx(head), .head_kind(head_kind), .head_dest(head_dest),
      .head_value(head_value), .head_ready(head_ready),
      .head_mispred(head_mispred),
      .lookup_tag(lookup_tag), .lookup_ready(lookup_ready),
      .lookup_value(lookup_value)
   );

   rob_retire #(.DATA_W(DATA_W), .DEST_W(DEST_W), .REG_W(REG_W)) u_retire (
      .nonempty(occ != '0), .head_kind(head_kind), .head_dest(head_dest),
      .head_value(head_value), .head_ready(head_ready),
      .head_mispred(head_mispred), .retire(retire),
      .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
      .mem_wr_en(mem_wr_en), .flush(flush)
   );

   assign reg_wr_data = head_value;
   assign mem_wr_addr = head_dest;
   assign mem_wr_data = head_value;
   assign redirect_pc = head_value;
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alloc_valid,
   input logic              full,
   input logic              retire,
   input logic [CNT_W-1:0]  occ,
   input logic              cdb_valid,
   input logic [IDX_W-1:0]  cdb_tag,
   input logic [DATA_W-1:0] cdb_value,
   input logic [IDX_W-1:0]  lookup_tag,
   input logic              lookup_ready,
   input logic [DATA_W-1:0] lookup_value,
   input logic              reg_wr_en,
   input logic              mem_wr_en,
   input logic              flush
);
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (occ == '0));

   a_r5_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_wr_en, mem_wr_en, flush}));

   a_r4_commit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en || mem_wr_en || flush) |-> (occ != '0));

   a_r3_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && !full && !flush && !retire) |=> (occ == $past(occ) + 1'b1));

   a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !retire) |=> full);

   a_r10_cdb_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && cdb_tag == lookup_tag) |-> (lookup_ready && lookup_value == cdb_value));
endmodule

bind spec_rob rob_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rob_checker (
   .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .full(full),
   .retire(retire), .occ(occ), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
   .cdb_value(cdb_value), .lookup_tag(lookup_tag), .lookup_ready(lookup_ready),
   .lookup_value(lookup_value), .reg_wr_en(reg_wr_en), .mem_wr_en(mem_wr_en),
   .flush(flush)
);

// File: tb/test_spec_rob.sv
module test_spec_rob;
   localparam int DEPTH = 8, DATA_W = 32, DEST_W = 16, REG_W = 5, IDX_W = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic alloc_valid = 0; logic [1:0] alloc_kind = 0; logic [DEST_W-1:0] alloc_dest = 0;
   logic [IDX_W-1:0] alloc_tag; logic full;
   logic cdb_valid = 0; logic [IDX_W-1:0] cdb_tag = 0; logic [DATA_W-1:0] cdb_value = 0;
   logic cdb_mispredict = 0; logic [IDX_W-1:0] lookup_tag = 0;
   logic lookup_ready; logic [DATA_W-1:0] lookup_value;
   logic reg_wr_en; logic [REG_W-1:0] reg_wr_idx; logic [DATA_W-1:0] reg_wr_data;
   logic mem_wr_en; logic [DEST_W-1:0] mem_wr_addr; logic [DATA_W-1:0] mem_wr_data;
   logic flush; logic [DATA_W-1:0] redirect_pc;

   int total = 0, bad = 0;
   bit finished = 0;

   spec_rob #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .REG_W(REG_W)) i_spec_rob (.*);

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] kind_of(int i);
      if (i == 3) return 2'd2;
      return (i % 2 == 1) ? 2'd1 : 2'd0;
   endfunction

   function automatic logic [DATA_W-1:0] val_of(int i);
      return 32'hA000 + 32'(i * 3);
   endfunction

   task automatic idle_outputs(string req);
      chk(req, {reg_wr_en, mem_wr_en, flush}, 3'b000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 full", full, 0);
      chk("R1 alloc_tag", alloc_tag, 0);
      idle_outputs("R1 idle");

      // R3 fill all slots in order
      for (int i = 0; i < DEPTH; i++) begin
         chk("R3 alloc_tag", alloc_tag, i);
         chk("R8 not full", full, 0);
         alloc_valid = 1; alloc_kind = kind_of(i); alloc_dest = 16'(16'h100 + i);
         @(negedge clk);
      end
      chk("R8 full", full, 1);
      alloc_kind = 2'd0; alloc_dest = 16'h1FF;   // offered while full
      @(negedge clk);
      alloc_valid = 0;
      chk("R8 alloc ignored tag", alloc_tag, 0);
      chk("R8 still full", full, 1);

      // R4 complete 7..1, head stays unfinished
      for (int t = DEPTH - 1; t >= 1; t--) begin
         cdb_valid = 1; cdb_tag = 3'(t); cdb_value = val_of(t); cdb_mispredict = 0;
         @(negedge clk);
         idle_outputs("R4 head not ready");
      end
      cdb_valid = 0;
      lookup_tag = 3'd5; #1;
      chk("R10 lookup ready", lookup_ready, 1);
      chk("R10 lookup value", lookup_value, val_of(5));
      lookup_tag = 3'd0; #1;
      chk("R10 lookup not ready", lookup_ready, 0);

      cdb_valid = 1; cdb_tag = 3'd0; cdb_value = val_of(0);
      @(negedge clk);
      cdb_valid = 0;
      for (int k = 0; k < DEPTH; k++) begin
         if (k == 1) chk("R8 full drops", full, 0);
         case (kind_of(k))
            2'd0: begin
               chk("R2 reg_wr_en", {reg_wr_en, mem_wr_en, flush}, 3'b100);
               chk("R2 reg_wr_idx", reg_wr_idx, k);
               chk("R2 reg_wr_data", reg_wr_data, val_of(k));
            end
            2'd1: begin
               chk("R5 mem_wr_en", {reg_wr_en, mem_wr_en, flush}, 3'b010);
               chk("R5 mem_wr_addr", mem_wr_addr, 16'h100 + k);
               chk("R5 mem_wr_data", mem_wr_data, val_of(k));
            end
            default: chk("R7 good branch", {reg_wr_en, mem_wr_en, flush}, 3'b000);
         endcase
         @(negedge clk);
      end
      idle_outputs("R5 empty after drain");
      chk("R3 wrapped tag", alloc_tag, 0);

      // R6 / R9 mispredict flush
      for (int i = 0; i < 4; i++) begin
         alloc_valid = 1; alloc_dest = 16'(16'h200 + i);
         alloc_kind = (i == 1) ? 2'd2 : (i == 3) ? 2'd1 : 2'd0;
         @(negedge clk);
      end
      alloc_valid = 0;
      cdb_valid = 1; cdb_mispredict = 0;
      cdb_tag = 3'd2; cdb_value = 32'h22; @(negedge clk);
      cdb_tag = 3'd3; cdb_value = 32'h33; @(negedge clk);
      cdb_tag = 3'd1; cdb_value = 32'hBEEF; cdb_mispredict = 1; @(negedge clk);
      cdb_tag = 3'd0; cdb_value = 32'h11; cdb_mispredict = 0; @(negedge clk);
      cdb_valid = 0;
      chk("R2 reg before branch", {reg_wr_en, mem_wr_en, flush}, 3'b100);
      chk("R2 reg idx", reg_wr_idx, 5'h00);
      @(negedge clk);
      chk("R6 flush", {reg_wr_en, mem_wr_en, flush}, 3'b001);
      chk("R6 redirect_pc", redirect_pc, 32'hBEEF);
      alloc_valid = 1; alloc_kind = 2'd0; alloc_dest = 16'h3;  // offered in flush cycle
      @(negedge clk);
      alloc_valid = 0;
      idle_outputs("R9 nothing after flush");
      chk("R9 alloc_tag", alloc_tag, 0);
      chk("R9 full", full, 0);
      @(negedge clk);
      idle_outputs("R9 younger discarded");

      // R10 same-cycle forwarding
      alloc_valid = 1; alloc_kind = 2'd0; alloc_dest = 16'h5;
      @(negedge clk);
      alloc_valid = 0;
      lookup_tag = 3'd0; #1;
      chk("R10 pending", lookup_ready, 0);
      cdb_valid = 1; cdb_tag = 3'd0; cdb_value = 32'h1234; #1;
      chk("R10 fwd ready", lookup_ready, 1);
      chk("R10 fwd value", lookup_value, 32'h1234);
      idle_outputs("R4 not yet retired");
      @(negedge clk);
      cdb_valid = 0;
      chk("R2 fwd entry retires", {reg_wr_en, reg_wr_idx, reg_wr_data}, {1'b1, 5'd5, 32'h1234});
      @(negedge clk);
      idle_outputs("R5 empty");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule